// File: doc/BRIEF.md
# Programmable Length Delay Line

This block delays a stream of data words by a number of clocks that is set at run time. A word enters through an input register, passes through a variable delay section held in a memory, and leaves through an output register. The total latency is therefore the programmed length value plus two. A length value of zero skips the memory entirely and leaves only the two framing registers.

A mode input switches the block between two uses. In pass-through mode it is a programmable pipeline: a fresh input word is taken on every enabled clock. In loop mode the output word is fed back into the input register, so whatever the line holds circulates with a period equal to the total length. The block also has an active-low clock enable that freezes every internal register, an active-low output enable that gates only the output port, and a length load strobe that saturates out-of-range requests and raises a sticky error flag. The length word is an unsigned binary number. All control inputs are captured one clock before they act.

Top module: `prog_delay_line`

## Requirements
- R1: A synchronous active-high reset clears the input and output registers, the memory pointer, the registered mode bit, the error flag and the stored length (length becomes 0). After reset the clock is enabled and, with `oe_n` low, `dout` reads 0.
- R2: With stored length L (0 to 1279) in pass-through mode, a word sampled from `din` on an advancing edge k is on `dout` after advancing edge k+L+1, so the total delay counting the capturing edge is L+2 clocks.
- R3: With stored length 0, the memory is bypassed and a word sampled on one advancing edge appears on `dout` after the next advancing edge.
- R4: `len_word` is stored only on an advancing edge at which `len_load_n` is low. At any other edge the stored length, and so the delay, is kept whatever `len_word` carries.
- R5: A requested length above 1279 is stored as 1279 (delay 1281) and sets `len_err`, which stays high until reset, including across later legal loads.
- R6: While the registered mode bit is 1 (loop mode), the input register takes the output register's word instead of `din`, so `dout` repeats with a period of L+2 advancing edges and `din` has no effect.
- R7: `recirc` is registered on an advancing edge and steers the input register only from the following advancing edge on; the edge that samples a new `recirc` value still moves data under the old mode.
- R8: `clk_en_n` is registered on every edge. An edge advances the block only if the registered enable was 1 (that is, `clk_en_n` was low one edge earlier). On a non-advancing edge, data registers, pointer, mode, length and error all hold.
- R9: `oe_n` high forces `dout` to 0 and `dout_vld` to 0. It never alters data movement, so the stream seen after `oe_n` returns low equals the stream that would have been seen without the gating.
- R10: `len_word` is an 11-bit unsigned value with bit 10 the most significant bit; for example, 11'b000_0100_0001 selects L=65 and a delay of 67 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 10 | Data word into the line |
| recirc | input | 1 | Mode: 0 pass-through, 1 loop the output back to the input |
| len_word | input | 11 | Requested memory length, unsigned, bit 10 MSB |
| len_load_n | input | 1 | Length load strobe, active low |
| clk_en_n | input | 1 | Clock enable, active low, acts one edge late |
| oe_n | input | 1 | Output enable, active low |
| dout | output | 10 | Delayed word, 0 while disabled |
| dout_vld | output | 1 | High when the output port is driven |
| len_err | output | 1 | Sticky flag for an over-range length request |

## Verification
The assertions assume that `rst` is held high across the first clock edge, so the enable, mode and length registers start from known values, and that the memory contents seen on the first pass after a length change are not relied upon. The bench asserts reset at time zero for two edges and compares outputs against its own model only where the model knows the word, marking every memory slot unknown after each load. The bench also fills the line with a known pattern for at least L+3 clocks before it measures a latency with a marker word.

// File: rtl/pdl_pkg.sv
package pdl_pkg;
   localparam int PDL_DATA_W  = 10;
   localparam int PDL_LEN_W   = 11;
   localparam int PDL_MAX_LEN = 1279;

   typedef enum logic {
      MODE_PASS = 1'b0,
      MODE_LOOP = 1'b1
   } pdl_mode_e;
endpackage

// File: rtl/pdl_ctrl.sv
module pdl_ctrl #(
   parameter int LEN_W   = 11,
   parameter int MAX_LEN = 1279
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clk_en_n,
   input  logic             len_load_n,
   input  logic [LEN_W-1:0] len_word,
   input  logic             recirc,
   output logic             adv,
   output pdl_pkg::pdl_mode_e mode,
   output logic [LEN_W-1:0] len,
   output logic             restart,
   output logic             err
);
   localparam logic [LEN_W-1:0] LIMIT = LEN_W'(MAX_LEN);

   initial begin
      assert (MAX_LEN < (2 ** LEN_W))
         else $error("pdl_ctrl: MAX_LEN does not fit LEN_W");
   end

   logic             en_q;
   logic             over;
   logic [LEN_W-1:0] len_sat;

   assign over    = (len_word > LIMIT);
   assign len_sat = over ? LIMIT : len_word;
   assign adv     = en_q;
   assign restart = en_q & ~len_load_n;

   always_ff @(posedge clk) begin
      if (rst) en_q <= 1'b1;
      else     en_q <= ~clk_en_n;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         mode <= pdl_pkg::MODE_PASS;
         len  <= '0;
         err  <= 1'b0;
      end else if (en_q) begin
         mode <= recirc ? pdl_pkg::MODE_LOOP : pdl_pkg::MODE_PASS;
         if (!len_load_n) begin
            len <= len_sat;
            err <= err | over;
         end
      end
   end

   assert_reset_state_R1: assert property (@(posedge clk)
      rst |=> (len == '0 && !err && mode == pdl_pkg::MODE_PASS && en_q));

   assert_len_in_range_R5: assert property (@(posedge clk) disable iff (rst)
      len <= LIMIT);

   assert_err_sticky_R5: assert property (@(posedge clk) disable iff (rst)
      err |=> err);

   assert_len_kept_R4: assert property (@(posedge clk) disable iff (rst)
      (!en_q || len_load_n) |=> $stable(len));

   assert_frozen_ctrl_R8: assert property (@(posedge clk) disable iff (rst)
      !en_q |=> ($stable(mode) && $stable(err)));
endmodule

// File: rtl/pdl_ram_stage.sv
module pdl_ram_stage #(
   parameter int DATA_W = 10,
   parameter int LEN_W  = 11,
   parameter int DEPTH  = 1279
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              adv,
   input  logic              restart,
   input  logic [LEN_W-1:0]  len,
   input  logic [DATA_W-1:0] d_in,
   output logic [DATA_W-1:0] tap
);
   initial begin
      assert (DATA_W >= 1) else $error("pdl_ram_stage: DATA_W must be positive");
      assert (DEPTH >= 0 && DEPTH < (2 ** LEN_W))
         else $error("pdl_ram_stage: DEPTH out of range for LEN_W");
   end

   generate
      if (DEPTH == 0) begin : g_bypass
         assign tap = d_in;
      end else begin : g_mem
         localparam int PTR_W = LEN_W;
         localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

         logic [DATA_W-1:0] mem [DEPTH];
         logic [PTR_W-1:0]  ptr;
         logic              bypass;
         logic              at_end;

         assign bypass = (len == '0);
         assign at_end = (ptr == (len - ONE));
         assign tap    = bypass ? d_in : mem[ptr];

         always_ff @(posedge clk) begin
            if (rst) begin
               ptr <= '0;
            end else if (adv) begin
               if (restart || bypass || at_end) ptr <= '0;
               else                             ptr <= ptr + ONE;
            end
         end

         always_ff @(posedge clk) begin
            if (adv && !bypass) mem[ptr] <= d_in;
         end

         assert_ptr_range_R2: assert property (@(posedge clk) disable iff (rst)
            (ptr == '0) || (ptr < len));

         assert_ptr_hold_R8: assert property (@(posedge clk) disable iff (rst)
            !adv |=> $stable(ptr));

         assert_ptr_restart_R4: assert property (@(posedge clk) disable iff (rst)
            (adv && restart) |=> (ptr == '0));
      end
   endgenerate
endmodule

// File: rtl/prog_delay_line.sv
module prog_delay_line
   import pdl_pkg::*;
#(
   parameter int DATA_W  = PDL_DATA_W,
   parameter int LEN_W   = PDL_LEN_W,
   parameter int MAX_LEN = PDL_MAX_LEN
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] din,
   input  logic              recirc,
   input  logic [LEN_W-1:0]  len_word,
   input  logic              len_load_n,
   input  logic              clk_en_n,
   input  logic              oe_n,
   output logic [DATA_W-1:0] dout,
   output logic              dout_vld,
   output logic              len_err
);
   logic              adv;
   pdl_mode_e         mode;
   logic [LEN_W-1:0]  len;
   logic              restart;
   logic [DATA_W-1:0] in_q;
   logic [DATA_W-1:0] out_q;
   logic [DATA_W-1:0] tap;

   pdl_ctrl #(
      .LEN_W   (LEN_W),
      .MAX_LEN (MAX_LEN)
   ) u_ctrl (
      .clk        (clk),
      .rst        (rst),
      .clk_en_n   (clk_en_n),
      .len_load_n (len_load_n),
      .len_word   (len_word),
      .recirc     (recirc),
      .adv        (adv),
      .mode       (mode),
      .len        (len),
      .restart    (restart),
      .err        (len_err)
   );

   pdl_ram_stage #(
      .DATA_W (DATA_W),
      .LEN_W  (LEN_W),
      .DEPTH  (MAX_LEN)
   ) u_ram (
      .clk     (clk),
      .rst     (rst),
      .adv     (adv),
      .restart (restart),
      .len     (len),
      .d_in    (in_q),
      .tap     (tap)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         in_q  <= '0;
         out_q <= '0;
      end else if (adv) begin
         in_q  <= (mode == MODE_LOOP) ? out_q : din;
         out_q <= tap;
      end
   end

   assign dout     = oe_n ? '0 : out_q;
   assign dout_vld = ~oe_n;

   assert_bypass_two_stage_R3: assert property (@(posedge clk) disable iff (rst)
      (adv && len == '0) |=> (out_q == $past(in_q)));

   assert_loop_feedback_R6: assert property (@(posedge clk) disable iff (rst)
      (adv && mode == MODE_LOOP) |=> (in_q == $past(out_q)));

   assert_pass_capture_R7: assert property (@(posedge clk) disable iff (rst)
      (adv && mode == MODE_PASS) |=> (in_q == $past(din)));

   assert_frozen_data_R8: assert property (@(posedge clk) disable iff (rst)
      !adv |=> ($stable(in_q) && $stable(out_q)));
endmodule

// File: tb/prog_delay_line_tb.sv
`timescale 1ns/1ps
module prog_delay_line_tb;
   localparam int DW   = 10;
   localparam int LW   = 11;
   localparam int LMAX = 1279;

   logic          clk = 1'b0;
   logic          rst;
   logic [DW-1:0] din;
   logic          recirc;
   logic [LW-1:0] len_word;
   logic          len_load_n;
   logic          clk_en_n;
   logic          oe_n;
   logic [DW-1:0] dout;
   logic          dout_vld;
   logic          len_err;

   always #4 clk = ~clk;

   prog_delay_line u_dut (
      .clk(clk), .rst(rst), .din(din), .recirc(recirc), .len_word(len_word),
      .len_load_n(len_load_n), .clk_en_n(clk_en_n), .oe_n(oe_n),
      .dout(dout), .dout_vld(dout_vld), .len_err(len_err)
   );

   int    n_chk  = 0;
   int    n_fail = 0;
   bit    done   = 0;
   string cur_req = "R1";

   // reference model state
   bit            m_en, m_mode, m_err;
   int            m_len;
   logic [DW-1:0] m_in, m_out;
   bit            m_iv, m_ov;
   logic [DW-1:0] mr [0:LMAX-1];
   bit            mv [0:LMAX-1];

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic model_edge();
      bit            a;
      int            l;
      logic [DW-1:0] o;
      bit            ov;
      if (rst) begin
         m_en = 1; m_mode = 0; m_err = 0; m_len = 0;
         m_in = '0; m_iv = 1; m_out = '0; m_ov = 1;
         return;
      end
      a    = m_en;
      m_en = !clk_en_n;
      if (!a) return;
      l  = m_len;
      o  = (l == 0) ? m_in : mr[l-1];
      ov = (l == 0) ? m_iv : mv[l-1];
      for (int i = l - 1; i >= 1; i--) begin
         mr[i] = mr[i-1];
         mv[i] = mv[i-1];
      end
      if (l > 0) begin
         mr[0] = m_in;
         mv[0] = m_iv;
      end
      if (m_mode) begin
         m_in = m_out; m_iv = m_ov;
      end else begin
         m_in = din; m_iv = 1;
      end
      m_out  = o;
      m_ov   = ov;
      m_mode = recirc;
      if (!len_load_n) begin
         m_err = m_err | (int'(len_word) > LMAX);
         m_len = (int'(len_word) > LMAX) ? LMAX : int'(len_word);
         for (int i = 0; i < LMAX; i++) mv[i] = 0;
      end
   endtask

   // one clock: model follows the edge, then outputs are compared mid-cycle
   task automatic step();
      @(posedge clk);
      #1;
      model_edge();
      #1;
      if (!rst) begin
         if (oe_n) check(dout == '0, {cur_req, "/R9 gated"}, int'(dout), 0);
         else if (m_ov) check(dout == m_out, cur_req, int'(dout), int'(m_out));
         check(dout_vld == !oe_n, "R9 vld", int'(dout_vld), int'(!oe_n));
         check(len_err == m_err, {cur_req, " err"}, int'(len_err), int'(m_err));
      end
   endtask

   task automatic load_len(input int v);
      len_word   = LW'(v);
      len_load_n = 1'b0;
      step();
      len_load_n = 1'b1;
   endtask

   // fill with zeros, send one marker, count edges until it shows
   task automatic measure(input int l_exp, input string req);
      int n;
      din = '0;
      repeat (l_exp + 3) step();
      din = 10'h3A5;
      step();
      din = '0;
      n = 0;
      while (n < l_exp + 10) begin
         step();
         n++;
         if (dout == 10'h3A5) break;
      end
      check(n == l_exp + 1, {req, " latency"}, n, l_exp + 1);
   endtask

   task automatic t_reset_r1();
      cur_req = "R1";
      rst = 1'b1;
      step();
      step();
      rst = 1'b0;
      #1;
      check(dout == '0, "R1 dout after reset", int'(dout), 0);
      check(len_err == 1'b0, "R1 err after reset", int'(len_err), 0);
      check(dout_vld == 1'b1, "R1 vld", int'(dout_vld), 1);
      din = 10'h011;
      step();
      check(dout == '0, "R1 cleared input reg", int'(dout), 0);
   endtask

   task automatic t_bypass_r3();
      cur_req = "R3";
      for (int i = 0; i < 12; i++) begin
         din = DW'(i * 37 + 5);
         step();
      end
      measure(0, "R3");
   endtask

   task automatic t_load_r4_r10();
      cur_req = "R10";
      load_len(11'b000_0100_0001);
      measure(65, "R10");
      cur_req = "R4";
      len_word = 11'd5;
      len_load_n = 1'b1;
      measure(65, "R4");
      // load strobe on a frozen edge must not take effect
      clk_en_n = 1'b1;
      step();
      len_word = 11'd2;
      len_load_n = 1'b0;
      step();
      step();
      len_load_n = 1'b1;
      clk_en_n = 1'b0;
      step();
      measure(65, "R4 frozen load");
   endtask

   task automatic t_sweep_r2();
      int ls [4] = '{1, 2, 7, 1279};
      cur_req = "R2";
      foreach (ls[j]) begin
         load_len(ls[j]);
         for (int i = 0; i < ls[j] + 40; i++) begin
            din = DW'(i * 13 + j);
            step();
         end
      end
      measure(7 - 7 + 1279, "R2 max");
   endtask

   task automatic t_clamp_r5();
      cur_req = "R5";
      load_len(2000);
      check(len_err == 1'b1, "R5 err set", int'(len_err), 1);
      measure(LMAX, "R5 clamped");
      load_len(3);
      check(len_err == 1'b1, "R5 err sticky", int'(len_err), 1);
      measure(3, "R5 legal after error");
   endtask

   task automatic t_loop_r6_r7();
      logic [DW-1:0] seq [0:19];
      cur_req = "R6";
      load_len(3);
      for (int i = 0; i < 8; i++) begin
         din = DW'(100 + i);
         step();
      end
      cur_req = "R7";
      recirc = 1'b1;
      din = 10'h2F0;
      step();
      din = 10'h2F1;
      step();
      cur_req = "R6";
      for (int i = 0; i < 20; i++) begin
         din = DW'(500 + i);
         step();
         seq[i] = dout;
      end
      for (int i = 0; i < 15; i++)
         check(seq[i] == seq[i+5], "R6 period", int'(seq[i+5]), int'(seq[i]));
      cur_req = "R7";
      recirc = 1'b0;
      for (int i = 0; i < 10; i++) begin
         din = DW'(700 + i);
         step();
      end
   endtask

   task automatic t_hold_r8();
      logic [DW-1:0] held;
      cur_req = "R8";
      load_len(4);
      for (int i = 0; i < 10; i++) begin
         din = DW'(300 + i);
         step();
      end
      clk_en_n = 1'b1;
      din = 10'h155;
      step();
      held = dout;
      for (int i = 0; i < 5; i++) begin
         din = DW'(900 + i);
         step();
         check(dout == held, "R8 frozen output", int'(dout), int'(held));
      end
      clk_en_n = 1'b0;
      for (int i = 0; i < 12; i++) begin
         din = DW'(40 + i);
         step();
      end
   endtask

   task automatic t_oe_r9();
      cur_req = "R9";
      for (int i = 0; i < 6; i++) begin
         din = DW'(600 + i);
         oe_n = 1'b1;
         step();
      end
      oe_n = 1'b0;
      for (int i = 0; i < 10; i++) begin
         din = DW'(20 + i);
         step();
      end
   endtask

   initial begin
      rst = 1'b1; din = '0; recirc = 1'b0; len_word = '0;
      len_load_n = 1'b1; clk_en_n = 1'b0; oe_n = 1'b0;
      t_reset_r1();
      t_bypass_r3();
      t_load_r4_r10();
      t_sweep_r2();
      t_clamp_r5();
      t_loop_r6_r7();
      t_hold_r8();
      t_oe_r9();
      cur_req = "R1";
      t_reset_r1();
      check(len_err == 1'b0, "R1 reset clears error", int'(len_err), 0);
      measure(0, "R1 length back to zero");
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule